// File: doc/BRIEF.md
# I/O Access Trap Monitor

This block snoops host I/O cycles. On every cycle marked valid it compares the address with a set of device windows. There are sixteen device trap bits and two bus-master channel bits. A window fires only when it is armed. When an armed window is hit, its sticky status bit is set. That bit can also produce a single-cycle power-management event pulse, or hold an interrupt level, depending on two per-bit enable masks. Software reaches the configuration and status through a byte-wide register port, and it clears status bits by writing ones to them.

Most windows sit at fixed legacy addresses. Three have a base picked by a 2-bit code. One window is fully programmable, with a 10-bit base and a 6-bit don't-care mask. The four disk traps are qualified by the drive currently selected on each disk channel. A 32-byte-aligned bus-master region is split into two 8-byte channel halves, and a hit on either half always raises an event. A software write can also raise an event directly.

Top module: `iotrap_monitor`

## Requirements
- R1: After a synchronous reset every register (addresses 0x00 to 0x10) reads 0, `pm_event` and `irq` are low, and no window is armed.
- R2: Each trap bit covers a fixed window, given as bit: addresses. Bit 0: 0x060 and 0x064 (one byte each). Bit 1: 0x3F8-0x3FF. Bit 2: 0x2F8-0x2FF. Bit 3: 0x378-0x37F and 0x278-0x27F. Bit 4: 0x3B0-0x3DF. Bit 5: 0x3F0-0x3F7 and 0x370-0x377. Bit 6: 0x200-0x207 and 0x388-0x38B.
- R3: Trap bit n is armed when bit n of enable set A (regs 0x00 low, 0x01 high) OR bit n of enable set B (regs 0x02/0x03) is 1. A hit on a window that is not armed changes no status and raises no event.
- R4: Register 0x0B selects the bases of three windows. Bits [1:0] pick the bit 7 window (length 0x14) with codes 0,1,2,3 giving 0x280, 0x260, 0x240, 0x220. Bits [3:2] pick the bit 8 window (length 4) with 0x330, 0x320, 0x310, 0x300. Bits [5:4] pick the bit 9 window (length 8) with 0xF40, 0xE80, 0x604, 0x530.
- R5: Trap bit 10 is the programmable window. Its base is {reg 0x0D[1:0], reg 0x0C} and its mask is reg 0x0D[7:2]. It hits when addr[15:10] is 0, addr[9:6] equals base[9:6], and (addr[5:0] & mask) equals (base[5:0] & mask).
- R6: Trap bits 11 and 12 cover 0x1F0-0x1F7; bits 13 and 14 cover 0x170-0x177. On each channel, the first bit hits only when its drive-select input is 0 and the second only when it is 1.
- R7: Register 0x0E bits [7:5] and register 0x0F give the bus-master base bits [15:5]. Base+0..7 is channel 0, armed by 0x0E bit 3. Base+8..15 is channel 1, armed by 0x0E bit 2. A hit sets bit 0 or bit 1 of register 0x0A and always raises an event.
- R8: Status registers 0x08, 0x09 and 0x0A clear each bit written with 1; bits written with 0 keep their value.
- R9: `pm_event` is high for exactly the one cycle after an edge at which a status bit is set with its event enable (regs 0x04/0x05) at 1, or a bus-master hit occurs.
- R10: `irq` is high, from the cycle after the setting edge, for as long as some status bit in 0x08/0x09 and its interrupt enable (regs 0x06/0x07) are both 1.
- R11: Writing register 0x10 with bit 1 set sets status bit 15 (reg 0x09 bit 7) and raises an event if event enable bit 15 is 1. A write with bit 1 clear sets nothing.
- R12: When a hit sets a status bit in the same cycle that software writes 1 to clear that bit, the bit ends up set. Clears of other bits in that write still take effect.
- R13: `reg_rdata` presents, one edge after it is applied, the register selected by `reg_addr`; plain registers read back the byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host I/O cycle strobe, one sample per clock |
| io_addr | input | 16 | Host I/O address |
| pri_drv_sel | input | 1 | Drive currently selected on the first disk channel |
| sec_drv_sel | input | 1 | Drive currently selected on the second disk channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| pm_event | output | 1 | Power-management event pulse |
| irq | output | 1 | Interrupt request level |

## Verification
A hit from the bus and a software write-one-to-clear of the status register can fall on the same clock edge. The bench provokes this by driving `io_valid` and `reg_we` in the same cycle. In one case the hit lands on the bit being cleared. In the other the hit lands on a neighbouring bit while a different bit is cleared. A status read afterwards has to show the hit bit set and only the untouched clear applied. The random phase mixes many address patterns against a bench model of every window. The base codes and drive selections change on each pass.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;
  localparam int IO_AW = 16;
  localparam int NDEV  = 16;
  localparam int NBM   = 2;

  localparam int T_KBD = 0, T_COM1 = 1, T_COM2 = 2, T_LPT = 3, T_VID = 4;
  localparam int T_FDC = 5, T_GAME = 6, T_SND = 7, T_MIDI = 8, T_CODEC = 9;
  localparam int T_PROG = 10, T_PM = 11, T_PS = 12, T_SM = 13, T_SS = 14;
  localparam int T_SOFT = 15;

  function automatic logic in_win(input logic [IO_AW-1:0] a,
                                  input logic [IO_AW-1:0] b,
                                  input logic [IO_AW-1:0] len);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < ({1'b0, b} + {1'b0, len}));
  endfunction

  function automatic logic [IO_AW-1:0] snd_base(input logic [1:0] c);
    case (c)
      2'd0: return 16'h0280;
      2'd1: return 16'h0260;
      2'd2: return 16'h0240;
      default: return 16'h0220;
    endcase
  endfunction

  function automatic logic [IO_AW-1:0] midi_base(input logic [1:0] c);
    case (c)
      2'd0: return 16'h0330;
      2'd1: return 16'h0320;
      2'd2: return 16'h0310;
      default: return 16'h0300;
    endcase
  endfunction

  function automatic logic [IO_AW-1:0] codec_base(input logic [1:0] c);
    case (c)
      2'd0: return 16'h0F40;
      2'd1: return 16'h0E80;
      2'd2: return 16'h0604;
      default: return 16'h0530;
    endcase
  endfunction
endpackage

// File: rtl/iotrap_decode.sv
module iotrap_decode
  import iotrap_pkg::*;
(
  input  logic [IO_AW-1:0] addr,
  input  logic             pri_drv,
  input  logic             sec_drv,
  input  logic [5:0]       sel_code,
  input  logic [9:0]       pw_base,
  input  logic [5:0]       pw_mask,
  input  logic [IO_AW-1:5] bm_base,
  output logic [NDEV-1:0]  dev_hit,
  output logic [NBM-1:0]   bm_hit
);
  logic pri_win, sec_win;

  always_comb begin
    pri_win = in_win(addr, 16'h01F0, 16'd8);
    sec_win = in_win(addr, 16'h0170, 16'd8);
    dev_hit = '0;
    dev_hit[T_KBD]   = (addr == 16'h0060) || (addr == 16'h0064);
    dev_hit[T_COM1]  = in_win(addr, 16'h03F8, 16'd8);
    dev_hit[T_COM2]  = in_win(addr, 16'h02F8, 16'd8);
    dev_hit[T_LPT]   = in_win(addr, 16'h0378, 16'd8) || in_win(addr, 16'h0278, 16'd8);
    dev_hit[T_VID]   = in_win(addr, 16'h03B0, 16'd48);
    dev_hit[T_FDC]   = in_win(addr, 16'h03F0, 16'd8) || in_win(addr, 16'h0370, 16'd8);
    dev_hit[T_GAME]  = in_win(addr, 16'h0200, 16'd8) || in_win(addr, 16'h0388, 16'd4);
    dev_hit[T_SND]   = in_win(addr, snd_base(sel_code[1:0]), 16'h0014);
    dev_hit[T_MIDI]  = in_win(addr, midi_base(sel_code[3:2]), 16'd4);
    dev_hit[T_CODEC] = in_win(addr, codec_base(sel_code[5:4]), 16'd8);
    dev_hit[T_PROG]  = (addr[IO_AW-1:10] == '0) && (addr[9:6] == pw_base[9:6]) &&
                       (((addr[5:0] ^ pw_base[5:0]) & pw_mask) == 6'd0);
    dev_hit[T_PM]    = pri_win && !pri_drv;
    dev_hit[T_PS]    = pri_win &&  pri_drv;
    dev_hit[T_SM]    = sec_win && !sec_drv;
    dev_hit[T_SS]    = sec_win &&  sec_drv;
  end

  for (genvar ch = 0; ch < NBM; ch++) begin : g_bm
    assign bm_hit[ch] = (addr[IO_AW-1:5] == bm_base) && (addr[4:3] == 2'(ch));
  end

  // R6: at most one drive-qualified disk trap per address
  always_comb begin
    p_disk_onehot_r6: assert ($onehot0(dev_hit[T_SS:T_PM]))
      else $error("disk traps not exclusive");
  end
endmodule

// File: rtl/iotrap_regs.sv
module iotrap_regs
  import iotrap_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int NREG   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              io_valid,
  input  logic [NDEV-1:0]   raw_dev,
  input  logic [NBM-1:0]    raw_bm,
  output logic [5:0]        sel_code,
  output logic [9:0]        pw_base,
  output logic [5:0]        pw_mask,
  output logic [IO_AW-1:5]  bm_base,
  output logic [7:0]        rdata,
  output logic              evt_o,
  output logic              irq_o
);
  localparam int A_STS_LO = 8, A_STS_HI = 9, A_BM_STS = 10, A_SOFT = 16;

  logic [NREG*8-1:0] regs_flat;
  logic [NDEV-1:0]   en_a, en_b, evt_en, irq_en, sts, sts_set, sts_clr, sts_nxt;
  logic [NBM-1:0]    bm_sts, bm_arm, bm_set, bm_clr, bm_nxt;
  logic              soft_wr;

  assign en_a     = regs_flat[15:0];
  assign en_b     = regs_flat[31:16];
  assign evt_en   = regs_flat[47:32];
  assign irq_en   = regs_flat[63:48];
  assign sts      = regs_flat[79:64];
  assign bm_sts   = regs_flat[81:80];
  assign sel_code = regs_flat[93:88];
  assign pw_base  = {regs_flat[105:104], regs_flat[103:96]};
  assign pw_mask  = regs_flat[111:106];
  assign bm_base  = {regs_flat[127:120], regs_flat[119:117]};
  assign bm_arm   = {regs_flat[114], regs_flat[115]};

  function automatic logic wsel(input logic [REG_AW-1:0] a, input int n);
    return a == REG_AW'(n);
  endfunction

  always_comb begin
    soft_wr = reg_we && wsel(reg_addr, A_SOFT) && reg_wdata[1];
    sts_set = (io_valid ? (raw_dev & (en_a | en_b)) : '0);
    sts_set[T_SOFT] = soft_wr;
    bm_set  = io_valid ? (raw_bm & bm_arm) : '0;
    sts_clr = {(reg_we && wsel(reg_addr, A_STS_HI)) ? reg_wdata : 8'h00,
               (reg_we && wsel(reg_addr, A_STS_LO)) ? reg_wdata : 8'h00};
    bm_clr  = (reg_we && wsel(reg_addr, A_BM_STS)) ? reg_wdata[NBM-1:0] : '0;
    sts_nxt = (sts & ~sts_clr) | sts_set;
    bm_nxt  = (bm_sts & ~bm_clr) | bm_set;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    if (g == A_STS_LO || g == A_STS_HI) begin : g_sts
      always_ff @(posedge clk)
        if (rst) q <= 8'h00;
        else     q <= sts_nxt[(g-A_STS_LO)*8 +: 8];
    end else if (g == A_BM_STS) begin : g_bm
      always_ff @(posedge clk)
        if (rst) q <= 8'h00;
        else     q <= {{(8-NBM){1'b0}}, bm_nxt};
    end else begin : g_plain
      always_ff @(posedge clk)
        if (rst)                          q <= 8'h00;
        else if (reg_we && wsel(reg_addr, g)) q <= reg_wdata;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
      evt_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      rdata <= (int'(reg_addr) < NREG) ? regs_flat[int'(reg_addr)*8 +: 8] : 8'h00;
      evt_o <= (|(sts_set & evt_en)) || (|bm_set);
      irq_o <= |(sts_nxt & irq_en);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sts == '0 && !evt_o && !irq_o));
  p_bm_event_r7: assert property (@(posedge clk) disable iff (rst)
    (io_valid && |(raw_bm & bm_arm)) |=> evt_o);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we) |-> ((sts & $past(sts)) == $past(sts)));
  p_event_cause_r9: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> $past(io_valid || reg_we));
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(io_valid || reg_we));
  p_hit_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (io_valid && |(raw_dev & (en_a | en_b))) |=>
      ((sts & $past(raw_dev & (en_a | en_b))) == $past(raw_dev & (en_a | en_b))));
endmodule

// File: rtl/iotrap_monitor.sv
module iotrap_monitor
  import iotrap_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic [15:0]       io_addr,
  input  logic              pri_drv_sel,
  input  logic              sec_drv_sel,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              pm_event,
  output logic              irq
);
  localparam int NREG = 17;

  logic [NDEV-1:0]  dev_hit;
  logic [NBM-1:0]   bm_hit;
  logic [5:0]       sel_code;
  logic [9:0]       pw_base;
  logic [5:0]       pw_mask;
  logic [IO_AW-1:5] bm_base;

  iotrap_decode u_dec (
    .addr    (io_addr),
    .pri_drv (pri_drv_sel),
    .sec_drv (sec_drv_sel),
    .sel_code(sel_code),
    .pw_base (pw_base),
    .pw_mask (pw_mask),
    .bm_base (bm_base),
    .dev_hit (dev_hit),
    .bm_hit  (bm_hit)
  );

  iotrap_regs #(.REG_AW(REG_AW), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .io_valid (io_valid),
    .raw_dev  (dev_hit),
    .raw_bm   (bm_hit),
    .sel_code (sel_code),
    .pw_base  (pw_base),
    .pw_mask  (pw_mask),
    .bm_base  (bm_base),
    .rdata    (reg_rdata),
    .evt_o    (pm_event),
    .irq_o    (irq)
  );
endmodule

// File: tb/iotrap_monitor_test.sv
module iotrap_monitor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic pri_drv_sel = 1'b0, sec_drv_sel = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic pm_event, irq;

  int nvec = 0, nerr = 0;
  logic last_evt, last_irq;
  logic [7:0] rv;

  always #5 clk = ~clk;

  iotrap_monitor uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
    last_evt = pm_event; last_irq = irq;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic acc(input logic [15:0] a);
    @(negedge clk); io_valid = 1'b1; io_addr = a;
    @(negedge clk); io_valid = 1'b0;
    last_evt = pm_event; last_irq = irq;
  endtask

  function automatic logic win(input logic [15:0] a, input int b, input int l);
    return (int'(a) >= b) && (int'(a) < b + l);
  endfunction

  function automatic logic [15:0] exp_dev(input logic [15:0] a, input logic [5:0] s,
      input logic [9:0] pb, input logic [5:0] pm, input logic dp, input logic ds);
    logic [15:0] e;
    int sb[4], mb[4], cb[4];
    sb = '{'h280, 'h260, 'h240, 'h220};
    mb = '{'h330, 'h320, 'h310, 'h300};
    cb = '{'hF40, 'hE80, 'h604, 'h530};
    e = '0;
    e[0]  = (a == 16'h60) || (a == 16'h64);
    e[1]  = win(a, 'h3F8, 8);
    e[2]  = win(a, 'h2F8, 8);
    e[3]  = win(a, 'h378, 8) || win(a, 'h278, 8);
    e[4]  = win(a, 'h3B0, 48);
    e[5]  = win(a, 'h3F0, 8) || win(a, 'h370, 8);
    e[6]  = win(a, 'h200, 8) || win(a, 'h388, 4);
    e[7]  = win(a, sb[s[1:0]], 'h14);
    e[8]  = win(a, mb[s[3:2]], 4);
    e[9]  = win(a, cb[s[5:4]], 8);
    e[10] = (a[15:10] == 0) && (a[9:6] == pb[9:6]) && ((a[5:0] & pm) == (pb[5:0] & pm));
    e[11] = win(a, 'h1F0, 8) && !dp;
    e[12] = win(a, 'h1F0, 8) &&  dp;
    e[13] = win(a, 'h170, 8) && !ds;
    e[14] = win(a, 'h170, 8) &&  ds;
    return e;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int bases[28];
    logic [15:0] ev;
    logic [9:0] pb;
    logic [5:0] pm;
    logic [5:0] sel;
    logic [15:0] a, e;
    logic [1:0] eb;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 event", pm_event, 0);
    chk("R1 irq", irq, 0);
    foreach (bases[i]) bases[i] = 0;
    for (int r = 0; r < 17; r++) begin
      rd(r[4:0], rv); chk($sformatf("R1 reg %0h", r), rv, 0);
    end
    acc(16'h03F8);
    chk("R3 disarmed event", last_evt, 0);
    rd(5'h08, rv); chk("R3 disarmed status", rv, 0);

    // R3 arm via set B, R9 event pulse
    wr(5'h02, 8'h02); wr(5'h04, 8'h02);
    acc(16'h03FA);
    chk("R9 event pulse", last_evt, 1);
    @(negedge clk); chk("R9 pulse one cycle", pm_event, 0);
    rd(5'h08, rv); chk("R3 arm by set B", rv, 8'h02);
    acc(16'h02F8);
    chk("R3 unarmed no event", last_evt, 0);
    rd(5'h08, rv); chk("R3 unarmed no status", rv, 8'h02);
    // R8 W1C
    wr(5'h08, 8'h00); rd(5'h08, rv); chk("R8 zero keeps", rv, 8'h02);
    wr(5'h08, 8'h02); rd(5'h08, rv); chk("R8 one clears", rv, 8'h00);

    // R10 irq level
    wr(5'h06, 8'h02);
    acc(16'h03F8);
    chk("R10 irq set", last_irq, 1);
    repeat (3) @(negedge clk);
    chk("R10 irq held", irq, 1);
    wr(5'h08, 8'h02);
    chk("R10 irq drops on clear", last_irq, 0);
    wr(5'h06, 8'h00); wr(5'h02, 8'h00);

    // R11 software event
    wr(5'h05, 8'h80);
    wr(5'h10, 8'h01);
    chk("R11 bit1 clear no event", last_evt, 0);
    rd(5'h09, rv); chk("R11 bit1 clear no status", rv, 0);
    wr(5'h10, 8'h02);
    chk("R11 soft event", last_evt, 1);
    rd(5'h09, rv); chk("R11 soft status", rv, 8'h80);
    wr(5'h09, 8'h80);

    // R12 hit and clear same cycle
    wr(5'h00, 8'h06);
    acc(16'h03F8);
    @(negedge clk); io_valid = 1'b1; io_addr = 16'h03F9; reg_we = 1'b1; reg_addr = 5'h08; reg_wdata = 8'h02;
    @(negedge clk); io_valid = 1'b0; reg_we = 1'b0;
    rd(5'h08, rv); chk("R12 same bit hit wins", rv, 8'h02);
    @(negedge clk); io_valid = 1'b1; io_addr = 16'h02FF; reg_we = 1'b1; reg_addr = 5'h08; reg_wdata = 8'h02;
    @(negedge clk); io_valid = 1'b0; reg_we = 1'b0;
    rd(5'h08, rv); chk("R12 other clear applies", rv, 8'h04);
    wr(5'h08, 8'hFF);

    // R6 disk drive qualification
    wr(5'h01, 8'h78);
    pri_drv_sel = 1'b1; sec_drv_sel = 1'b0;
    acc(16'h01F3); acc(16'h0177);
    rd(5'h09, rv); chk("R6 drive select", rv, 8'h30);
    wr(5'h09, 8'hFF);

    // R7 bus master
    wr(5'h0E, 8'h08); wr(5'h0F, 8'hC0);
    acc(16'hC004);
    chk("R7 bm event", last_evt, 1);
    acc(16'hC00C);
    chk("R7 unarmed half no event", last_evt, 0);
    rd(5'h0A, rv); chk("R7 bm status", rv, 8'h01);
    wr(5'h0A, 8'h01); rd(5'h0A, rv); chk("R8 bm clear", rv, 8'h00);

    // R5 programmable window, base 0x2C0 mask 0x3C
    wr(5'h0C, 8'hC0); wr(5'h0D, 8'hF2); wr(5'h01, 8'h07);
    acc(16'h02C3); rd(5'h09, rv); chk("R5 masked hit", rv, 8'h04);
    wr(5'h09, 8'hFF);
    acc(16'h02C4); rd(5'h09, rv); chk("R5 masked miss", rv, 8'h00);

    // R4 code 3 bases, R13 readback
    wr(5'h00, 8'h80); wr(5'h0B, 8'h3F);
    rd(5'h0B, rv); chk("R13 readback", rv, 8'h3F);
    acc(16'h0233); acc(16'h0303); acc(16'h0537);
    rd(5'h08, rv); chk("R4 sound base", rv, 8'h80);
    rd(5'h09, rv); chk("R4 midi codec base", rv, 8'h03);
    wr(5'h08, 8'hFF); wr(5'h09, 8'hFF);
    acc(16'h0234); rd(5'h08, rv); chk("R4 sound end", rv, 8'h00);

    // random phase: R2 R4 R5 R6 R7 R9
    ev = 16'($urandom); pb = 10'($urandom); pm = 6'($urandom);
    wr(5'h00, 8'hFF); wr(5'h01, 8'h7F);
    wr(5'h04, ev[7:0]); wr(5'h05, ev[15:8]);
    wr(5'h0C, pb[7:0]); wr(5'h0D, {pm, pb[9:8]});
    wr(5'h0E, 8'h0C); wr(5'h0F, 8'hC0);
    bases = '{'h60, 'h64, 'h3F8, 'h2F8, 'h378, 'h278, 'h3B0, 'h3F0, 'h370, 'h200, 'h388,
              'h280, 'h260, 'h240, 'h220, 'h330, 'h320, 'h310, 'h300, 'hF40, 'hE80,
              'h604, 'h530, 'h1F0, 'h170, 'hC000, 'hC008, int'(pb)};
    for (int it = 0; it < 250; it++) begin
      sel = 6'($urandom);
      pri_drv_sel = 1'($urandom); sec_drv_sel = 1'($urandom);
      wr(5'h0B, {2'b00, sel});
      if ($urandom % 4 == 0) a = 16'($urandom);
      else a = 16'(bases[$urandom % 28] + int'($urandom % 52) - 4);
      e  = exp_dev(a, sel, pb, pm, pri_drv_sel, sec_drv_sel);
      eb = {a[15:3] == 13'h1801, a[15:3] == 13'h1800};
      acc(a);
      chk($sformatf("R9 event addr %0h", a), last_evt, (|(e & ev)) || (|eb));
      rd(5'h08, rv); chk($sformatf("R2 low status addr %0h", a), rv, e[7:0]);
      rd(5'h09, rv); chk($sformatf("R4 high status addr %0h", a), rv, e[15:8]);
      rd(5'h0A, rv); chk($sformatf("R7 bm status addr %0h", a), rv, {6'b0, eb});
      wr(5'h08, 8'hFF); wr(5'h09, 8'hFF); wr(5'h0A, 8'h03);
    end
    finish_run();
  end
endmodule